// File: doc/BRIEF.md
# Oversampling UART Bit-Rate Generator

This block turns a stream of input-clock ticks into the timing strobes a UART transmitter and receiver need. Software picks one of two tick sources, loads a 16-bit divisor and a packed modulation word, then releases a hold bit. From then on the block emits a one-cycle bit strobe at the end of every bit period. In oversampling mode it also emits sixteen sample strobes per bit and a mid-bit strobe that marks where a receiver should sample.

In oversampling mode a bit is sixteen sample periods, each of which lasts the divisor in ticks. A fractional field lengthens a chosen number of those sample periods by one tick, spread evenly across the bit. A per-bit pattern lengthens individual bits of a character by one more tick. With oversampling off, the divisor alone sets the bit length and the pattern still applies. A receive start-edge input realigns all counters so that the mid-bit strobe falls halfway through the new bit.

The timing core is a three-state machine. HOLD: counters cleared, strobes silent. COUNT: ticks are counted toward the end of the current period. STRETCH: one added tick is waited out. The transitions are: release (HOLD to COUNT), stretch (COUNT to STRETCH, on the last base tick of a period that is due an added tick), finish (STRETCH to COUNT, on the added tick), wrap (COUNT to COUNT, on the last base tick of a period that is not lengthened), hold (any state to HOLD while the hold bit is set) and resync (any state to COUNT with counters cleared, on a start edge).

Top module: `uart_bitclk_gen`

## Requirements
- R1: With oversampling on (mode word bit 0 = 1) and pattern zero, bit strobes are spaced 16·D + F input ticks apart, where D is the effective divisor and F is the fractional field.
- R2: With oversampling off (mode word bit 0 = 0) and pattern zero, bit strobes are spaced D ticks apart. Divisor 16 without oversampling gives the same spacing as divisor 1 with oversampling and F = 0.
- R3: The mode word (register address 3) holds the per-bit pattern in bits 15:8, the fractional field F in bits 7:4 and the oversampling enable in bit 0. Bits 3:1 have no effect.
- R4: Register address 1 loads divisor bits 7:0 from write data 7:0, and address 2 loads divisor bits 15:8 from write data 7:0.
- R5: A divisor of 0 behaves as a divisor of 1.
- R6: Control register (address 0) bit 0 is the hold bit. It is set by reset. While it is set, no strobe is emitted and the counters stay cleared. Clearing it starts counting, and the first bit of a run has index 0.
- R7: Writes to addresses 1, 2 and 3 are ignored unless the hold bit is set.
- R8: In oversampling mode, each sample period lasts D or D+1 ticks. Exactly F sample periods of a bit are lengthened by the fractional field, and sample period 0 never is.
- R9: Pattern bit b (b = bit index 0..7, counting from the release or the last start edge and wrapping after 7) adds one tick to bit b. In oversampling mode the tick goes on sample period 0.
- R10: In oversampling mode, 16 sample strobes are emitted per bit, and the 16th coincides with the bit strobe. With oversampling off, no sample strobe is emitted.
- R11: In oversampling mode, a mid-bit strobe coincides with the 8th sample strobe of each bit and never with a bit strobe.
- R12: A start-edge pulse clears the tick, sample and bit counters in the cycle it is seen, and no strobe results from that cycle. Counting resumes with bit index 0.
- R13: Control register bit 1 selects the tick source: 0 selects tick_a, 1 selects tick_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 divisor low, 2 divisor high, 3 mode word |
| reg_wdata | input | 16 | Register write data |
| tick_a | input | 1 | Tick enable of input clock source 0 |
| tick_b | input | 1 | Tick enable of input clock source 1 |
| rx_start | input | 1 | Receive start-edge pulse, realigns counters |
| bit_en | output | 1 | One-cycle strobe at the end of each bit |
| sample_en | output | 1 | One-cycle strobe at the end of each 1/16 sample period |
| mid_en | output | 1 | One-cycle mid-bit strobe |

## Verification
Nine configurations are applied, and each is measured over eight consecutive bit periods. Plain divisors without oversampling, including 0 and a divisor using the high byte, tell divisor decoding apart from mode selection. Oversampling with fractional values of 0, 5, 7 and 15 separates the fractional spread from the base division. Patterns such as 0xA5 and 0x3C give each bit index a different length, which exposes errors in bit-index tracking and wraparound. The half-rate tick source doubles every interval. Directed tests cover reset and hold silence, writes ignored while running, and a start edge whose realignment is visible in the timing of both the mid-bit strobe and the bit strobe.

// File: rtl/ubg_pkg.sv
package ubg_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_STRETCH = 2'd2
    } tmr_state_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_DIV_LO = 2'd1;
    localparam logic [1:0] ADDR_DIV_HI = 2'd2;
    localparam logic [1:0] ADDR_MODE   = 2'd3;
endpackage

// File: rtl/ubg_regs.sv
module ubg_regs
    import ubg_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4,
    parameter int PAT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [15:0]       wr_data,
    output logic              hold_o,
    output logic              sel_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [PAT_W-1:0]  pat_o,
    output logic              os_o
);
    localparam int FRAC_LSB = 4;
    localparam int PAT_LSB  = 16 - PAT_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_o <= 1'b1;
            sel_o  <= 1'b0;
            div_o  <= '0;
            frac_o <= '0;
            pat_o  <= '0;
            os_o   <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL: begin
                    hold_o <= wr_data[0];
                    sel_o  <= wr_data[1];
                end
                ADDR_DIV_LO: if (hold_o) div_o[7:0] <= wr_data[7:0];
                ADDR_DIV_HI: if (hold_o) div_o[DIV_W-1:8] <= wr_data[DIV_W-9:0];
                ADDR_MODE: if (hold_o) begin
                    pat_o  <= wr_data[PAT_LSB +: PAT_W];
                    frac_o <= wr_data[FRAC_LSB +: FRAC_W];
                    os_o   <= wr_data[0];
                end
                default: ;
            endcase
        end
    end

    // R7: configuration frozen while running
    a_r7_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_o |=> $stable(div_o) && $stable(frac_o) && $stable(pat_o) && $stable(os_o));
endmodule

// File: rtl/ubg_mod_sched.sv
module ubg_mod_sched #(
    parameter int SAMPLES = 16,
    parameter int FRAC_W  = 4,
    parameter int PAT_W   = 8,
    localparam int SIDX_W = $clog2(SAMPLES),
    localparam int BIDX_W = $clog2(PAT_W)
) (
    input  logic [SIDX_W-1:0] sidx_i,
    input  logic [BIDX_W-1:0] bidx_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [PAT_W-1:0]  pat_i,
    input  logic              os_i,
    output logic              extra_o
);
    localparam int PROD_W = SIDX_W + 1 + FRAC_W;

    logic [PROD_W-1:0] acc_now;
    logic [PROD_W-1:0] acc_next;
    logic              frac_hit;
    logic              pat_hit;

    always_comb begin
        acc_now  = PROD_W'(sidx_i) * PROD_W'(frac_i);
        acc_next = acc_now + PROD_W'(frac_i);
        // an added tick whenever the running share crosses a whole step
        frac_hit = (acc_next >> SIDX_W) != (acc_now >> SIDX_W);
        pat_hit  = pat_i[bidx_i];
        if (os_i) extra_o = frac_hit || (pat_hit && (sidx_i == '0));
        else      extra_o = pat_hit;
    end
endmodule

// File: rtl/ubg_timer.sv
module ubg_timer
    import ubg_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int SAMPLES = 16,
    parameter int PAT_W   = 8,
    localparam int SIDX_W = $clog2(SAMPLES),
    localparam int BIDX_W = $clog2(PAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic              tick_i,
    input  logic              rx_start_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              os_i,
    input  logic              extra_i,
    output logic [SIDX_W-1:0] sidx_o,
    output logic [BIDX_W-1:0] bidx_o,
    output logic              bit_en_o,
    output logic              sample_en_o,
    output logic              mid_en_o
);
    localparam logic [SIDX_W-1:0] SIDX_LAST = SIDX_W'(SAMPLES - 1);
    localparam logic [SIDX_W-1:0] SIDX_MID  = SIDX_W'(SAMPLES / 2 - 1);

    tmr_state_e        state_q, state_d;
    logic [DIV_W-1:0]  cnt_q, cnt_d, div_eff;
    logic [SIDX_W-1:0] sidx_q, sidx_d;
    logic [BIDX_W-1:0] bidx_q, bidx_d;
    logic              last_base;
    logic              period_end;

    assign div_eff   = (div_i == '0) ? DIV_W'(1) : div_i;
    assign last_base = (cnt_q == div_eff - DIV_W'(1));
    assign sidx_o    = sidx_q;
    assign bidx_o    = bidx_q;

    // next state and counters
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        sidx_d     = sidx_q;
        bidx_d     = bidx_q;
        period_end = 1'b0;
        if (hold_i) begin
            state_d = ST_HOLD;
            cnt_d   = '0;
            sidx_d  = '0;
            bidx_d  = '0;
        end else if (rx_start_i) begin
            state_d = ST_COUNT;
            cnt_d   = '0;
            sidx_d  = '0;
            bidx_d  = '0;
        end else begin
            unique case (state_q)
                ST_HOLD: state_d = ST_COUNT;
                ST_COUNT: if (tick_i) begin
                    if (!last_base)   cnt_d = cnt_q + DIV_W'(1);
                    else if (extra_i) state_d = ST_STRETCH;
                    else              period_end = 1'b1;
                end
                ST_STRETCH: if (tick_i) begin
                    state_d    = ST_COUNT;
                    period_end = 1'b1;
                end
                default: state_d = ST_HOLD;
            endcase
            if (period_end) begin
                cnt_d = '0;
                if (os_i) begin
                    sidx_d = sidx_q + SIDX_W'(1);
                    if (sidx_q == SIDX_LAST) bidx_d = bidx_q + BIDX_W'(1);
                end else begin
                    bidx_d = bidx_q + BIDX_W'(1);
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
            sidx_q  <= '0;
            bidx_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sidx_q  <= sidx_d;
            bidx_q  <= bidx_d;
        end
    end

    // strobe outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_en_o    <= 1'b0;
            sample_en_o <= 1'b0;
            mid_en_o    <= 1'b0;
        end else begin
            bit_en_o    <= period_end && (!os_i || sidx_q == SIDX_LAST);
            sample_en_o <= period_end && os_i;
            mid_en_o    <= period_end && os_i && (sidx_q == SIDX_MID);
        end
    end

    // R6: silent while held
    a_r6_quiet_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !(bit_en_o || sample_en_o || mid_en_o));
    // R10: last sample strobe lines up with the bit strobe
    a_r10_bit_with_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (os_i && bit_en_o) |-> sample_en_o);
    // R10: no sample strobes without oversampling
    a_r10_no_sample_plain: assert property (@(posedge clk) disable iff (!rst_n)
        !os_i |-> !sample_en_o);
    // R11: mid strobe is a sample strobe and never a bit end
    a_r11_mid_is_sample: assert property (@(posedge clk) disable iff (!rst_n)
        mid_en_o |-> (sample_en_o && !bit_en_o));
    // R5: tick counter stays below the effective divisor
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HOLD) |-> (cnt_q < div_eff));
    // R12: start edge clears everything and yields no strobe
    a_r12_resync: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_start_i && !hold_i) |=> (cnt_q == '0 && sidx_q == '0 && bidx_q == '0 && !bit_en_o));
endmodule

// File: rtl/uart_bitclk_gen.sv
module uart_bitclk_gen #(
    parameter int DIV_W   = 16,
    parameter int SAMPLES = 16,
    parameter int FRAC_W  = 4,
    parameter int PAT_W   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    input  logic        tick_a,
    input  logic        tick_b,
    input  logic        rx_start,
    output logic        bit_en,
    output logic        sample_en,
    output logic        mid_en
);
    localparam int SIDX_W = $clog2(SAMPLES);
    localparam int BIDX_W = $clog2(PAT_W);

    logic              hold, sel, os, extra, tick;
    logic [DIV_W-1:0]  div;
    logic [FRAC_W-1:0] frac;
    logic [PAT_W-1:0]  pat;
    logic [SIDX_W-1:0] sidx;
    logic [BIDX_W-1:0] bidx;

    assign tick = sel ? tick_b : tick_a;

    ubg_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .PAT_W(PAT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .hold_o(hold), .sel_o(sel), .div_o(div),
        .frac_o(frac), .pat_o(pat), .os_o(os)
    );

    ubg_mod_sched #(.SAMPLES(SAMPLES), .FRAC_W(FRAC_W), .PAT_W(PAT_W)) u_sched (
        .sidx_i(sidx), .bidx_i(bidx), .frac_i(frac), .pat_i(pat),
        .os_i(os), .extra_o(extra)
    );

    ubg_timer #(.DIV_W(DIV_W), .SAMPLES(SAMPLES), .PAT_W(PAT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .hold_i(hold), .tick_i(tick),
        .rx_start_i(rx_start), .div_i(div), .os_i(os), .extra_i(extra),
        .sidx_o(sidx), .bidx_o(bidx), .bit_en_o(bit_en),
        .sample_en_o(sample_en), .mid_en_o(mid_en)
    );
endmodule

// File: tb/uart_bitclk_gen_test.sv
`timescale 1ns/1ps
module uart_bitclk_gen_test;
    typedef struct packed {
        logic [15:0] dv;
        logic [15:0] md;
        logic        sl;
    } vec_t;

    // R2 plain; R1 oversampled; R8 fraction; R9 pattern; R5 zero divisor;
    // R4 high byte; R13 slow source; R3 bits 3:1 set without effect
    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{16'd5,      16'h0000, 1'b0},
        '{16'd16,     16'h0000, 1'b0},
        '{16'd1,      16'h0001, 1'b0},
        '{16'd3,      16'h0051, 1'b0},
        '{16'd2,      16'hA5F1, 1'b0},
        '{16'd0,      16'h0000, 1'b0},
        '{16'd0,      16'h3C00, 1'b0},
        '{16'h0104,   16'h0000, 1'b1},
        '{16'd4,      16'h007F, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        tick_a = 1'b1;
    logic        tick_b = 1'b0;
    logic        rx_start = 1'b0;
    logic        bit_en, sample_en, mid_en;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;
    always @(negedge clk) tick_b <= ~tick_b;

    uart_bitclk_gen uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .tick_a(tick_a), .tick_b(tick_b),
        .rx_start(rx_start), .bit_en(bit_en), .sample_en(sample_en), .mid_en(mid_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // expected bit length in ticks, taken from R1, R2, R5 and R9
    function automatic int bit_ticks(int dv, int f, logic [7:0] pat, bit os, int b);
        int d = (dv == 0) ? 1 : dv;
        return (os ? 16 * d + f : d) + int'(pat[b]);
    endfunction

    task automatic measure(input int dv, input int f, input logic [7:0] pat,
                           input bit os, input int mult);
        int cb = 0, cs = 0, sc = 0, got = 0;
        int d = (dv == 0) ? 1 : dv;
        bit started = 1'b0;
        while (got < 9) begin
            @(negedge clk);
            cb++; cs++;
            if (sample_en) begin
                sc++;
                if (started) begin
                    n_chk++;
                    if (cs != d * mult && cs != (d + 1) * mult) begin
                        n_bad++;
                        $display("FAIL R8 sample interval: actual %0d expected %0d or %0d",
                                 cs, d * mult, (d + 1) * mult);
                    end
                end
                cs = 0;
            end
            if (mid_en && started) chk("R11 mid strobe sample position", sc, 8);
            if (bit_en) begin
                if (started) begin
                    chk("R1/R2/R9 bit period", cb, mult * bit_ticks(dv, f, pat, os, got % 8));
                    chk("R10 samples per bit", sc, os ? 16 : 0);
                end
                started = 1'b1; got++; cb = 0; sc = 0;
            end
        end
    endtask

    task automatic load(input logic [15:0] dv, input logic [15:0] md, input logic sl);
        wr(2'd0, {14'd0, sl, 1'b1});
        wr(2'd1, {8'd0, dv[7:0]});
        wr(2'd2, {8'd0, dv[15:8]});
        wr(2'd3, md);
        wr(2'd0, {14'd0, sl, 1'b0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hits;
        int first_mid, first_bit;
        // R6: reset state and default hold
        repeat (3) @(negedge clk);
        chk("R6 strobes in reset", int'(bit_en | sample_en | mid_en), 0);
        rst_n = 1'b1;
        hits = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (bit_en | sample_en | mid_en) hits++;
        end
        chk("R6 silent while held after reset", hits, 0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            load(VECS[i].dv, VECS[i].md, VECS[i].sl);
            measure(int'(VECS[i].dv), int'(VECS[i].md[7:4]), VECS[i].md[15:8],
                    VECS[i].md[0], VECS[i].sl ? 2 : 1);
        end

        // R7: configuration writes ignored while running
        load(16'd3, 16'h0000, 1'b0);
        wr(2'd1, 16'd9);
        wr(2'd3, 16'hFF11);
        measure(3, 0, 8'h00, 1'b0, 1);

        // R6: setting hold mid-run silences the strobes
        wr(2'd0, 16'h0001);
        hits = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (bit_en | sample_en | mid_en) hits++;
        end
        chk("R6 silent after hold set", hits, 0);

        // R12: start edge realigns; bit 0 carries the pattern tick (R9)
        load(16'd2, 16'h0101, 1'b0);
        hits = 0;
        while (hits < 3) begin
            @(negedge clk);
            if (bit_en) hits++;
        end
        repeat (5) @(negedge clk);
        rx_start = 1'b1;
        first_mid = 0; first_bit = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            rx_start = 1'b0;
            if (mid_en && first_mid == 0) first_mid = k;
            if (bit_en && first_bit == 0) first_bit = k;
        end
        chk("R12 mid strobe after start edge", first_mid, 18);
        chk("R12 bit strobe after start edge", first_bit, 34);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule